// File: doc/BRIEF.md
# Prioritized Active Interrupt Resolver

This block turns the three pending words of a banked interrupt controller into the single interrupt that should be serviced next. It takes the 21-bit basic pending word and the two 32-bit bank pending words and returns a valid flag and a 7-bit flat source number. A processor can therefore learn the active source with one read, instead of scanning three registers and applying the search order in software.

The basic word holds eight direct lines in bits 7:0. Bits 8 and 9 are summary bits for bank 1 and bank 2. Bits 10 to 14 are shortcut copies of bank-1 lines 7, 9, 10, 18 and 19. Bits 15 to 20 are shortcut copies of bank-2 lines 21, 22, 23, 24, 25 and 30. Flat numbers are assigned as follows: 0 to 7 for the direct lines, 8 plus the line for bank 1, and 40 plus the line for bank 2.

The search order is fixed. Direct lines come first, then the bank-1 shortcuts, then the bank-2 shortcuts. After that comes the rest of bank 1 and then the rest of bank 2, with the shortcut lines cleared from each bank word before it is searched. A separate combinational descriptor translator checks a (bank, index) pair and converts it to a flat number. The result can be registered or left combinational, chosen by a parameter. By default it is registered.

Top module: `irq_active_resolver`

## Requirements
- R1: When basic pending bits 20:0 are all zero, the result is not valid. Whenever the result is not valid, the number output is 7'h7F. A valid result is always below 72.
- R2: If any of basic bits 7:0 is set, the number is the index of the lowest such bit, whatever else is pending.
- R3: If no direct line is pending, basic bits 10,11,12,13,14 are searched in that order. They stand for bank-1 lines 7,9,10,18,19, and the first one set gives 8 plus its line.
- R4: If neither of the above applies, basic bits 15 to 20 are searched in order. They stand for bank-2 lines 21,22,23,24,25,30, and the first one set gives 40 plus its line.
- R5: If nothing above applies and basic bit 8 is set, bank-1 lines 7, 9, 10, 18 and 19 are cleared from the bank-1 word, and the result is 8 plus the lowest remaining set bit.
- R6: If nothing above applies and basic bit 9 is set, bank-2 lines 21 to 25 and 30 are cleared from the bank-2 word, and the result is 40 plus the lowest remaining set bit.
- R7: A summary bit whose cleared bank word is zero does not produce a result, and the search moves on. A bank word whose summary bit is clear is ignored. If nothing is found, the result is not valid.
- R8: The translator maps bank code 0 with index 0..7 to the index, bank code 1 with index 0..31 to 8 plus the index, and bank code 2 with index 0..31 to 40 plus the index, with the invalid flag low.
- R9: The translator raises the invalid flag and drives 7'h7F for bank code 3, and for any index beyond the range of its bank.
- R10: In registered mode, the result follows the pending inputs one clock later and is recomputed every cycle. During reset it reads not valid with number 7'h7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| basic_pend | input | 21 | Basic pending word: direct lines, summaries, shortcuts |
| bank1_pend | input | 32 | Bank-1 pending word |
| bank2_pend | input | 32 | Bank-2 pending word |
| desc_bank | input | 2 | Descriptor bank code |
| desc_index | input | 6 | Descriptor line index within the bank |
| irq_valid | output | 1 | A pending source was found |
| irq_num | output | 7 | Flat number of the source to service, 7'h7F when none |
| desc_num | output | 7 | Translated flat number, 7'h7F when invalid |
| desc_invalid | output | 1 | Descriptor bank or index is out of range |

## Verification
The resolver is driven with patterns that each set bits at two adjacent levels of the search order. Examples are a direct line together with shortcut bits, two shortcuts of the same bank, and a summary bit together with a shortcut of the other bank. A wrong level order or a wrong order within one level then yields a different number. The bank words are loaded with set shortcut lines below real lines, which exposes a missing mask. Bank words with a clear summary bit, and summaries whose cleared word is empty, separate "move on" from "stop". The translator is tried at the first and last legal index of every bank, one past each end, and with the unused bank code.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    localparam int BASIC_W     = 21;
    localparam int BANK_W      = 32;
    localparam int BANK_IDX_W  = $clog2(BANK_W);
    localparam int NUM_W       = 7;
    localparam int IDX_W       = 6;
    localparam int DIRECT_N    = 8;
    localparam int BANK1_BASE  = DIRECT_N;
    localparam int BANK2_BASE  = BANK1_BASE + BANK_W;
    localparam int SOURCES     = BANK2_BASE + BANK_W;
    localparam int SUM1_BIT    = 8;
    localparam int SUM2_BIT    = 9;
    localparam int SC1_N       = 5;
    localparam int SC2_N       = 6;
    localparam int SC1_BIT0    = 10;
    localparam int SC2_BIT0    = SC1_BIT0 + SC1_N;
    localparam int STAGES      = 5;
    localparam logic [NUM_W-1:0] NUM_NONE = '1;

    typedef struct packed {
        logic             valid;
        logic [NUM_W-1:0] num;
    } irq_result_t;

    typedef enum logic [1:0] {
        BANK_DIRECT = 2'd0,
        BANK_ONE    = 2'd1,
        BANK_TWO    = 2'd2,
        BANK_BAD    = 2'd3
    } bank_sel_e;

    localparam irq_result_t RESULT_NONE = '{valid: 1'b0, num: NUM_NONE};

    function automatic irq_result_t make_result(input logic [NUM_W-1:0] n);
        irq_result_t r;
        r.valid = 1'b1;
        r.num   = n;
        return r;
    endfunction

    // Bank line mirrored by shortcut slot k (search order within the bank).
    function automatic logic [BANK_IDX_W-1:0] sc_line(input int bank, input int k);
        logic [BANK_IDX_W-1:0] l;
        if (bank == 1) begin
            case (k)
                0:       l = 5'd7;
                1:       l = 5'd9;
                2:       l = 5'd10;
                3:       l = 5'd18;
                default: l = 5'd19;
            endcase
        end else begin
            case (k)
                0:       l = 5'd21;
                1:       l = 5'd22;
                2:       l = 5'd23;
                3:       l = 5'd24;
                4:       l = 5'd25;
                default: l = 5'd30;
            endcase
        end
        return l;
    endfunction

    function automatic logic [BANK_W-1:0] sc_mask(input int bank);
        logic [BANK_W-1:0] m;
        int n;
        m = '0;
        n = (bank == 1) ? SC1_N : SC2_N;
        for (int k = 0; k < n; k++) m[sc_line(bank, k)] = 1'b1;
        return m;
    endfunction

    function automatic logic [BANK_IDX_W-1:0] lowest_set(input logic [BANK_W-1:0] v);
        logic [BANK_IDX_W-1:0] r;
        r = '0;
        for (int i = BANK_W - 1; i >= 0; i--) if (v[i]) r = BANK_IDX_W'(i);
        return r;
    endfunction

endpackage

// File: rtl/irq_res_shortcut.sv
module irq_res_shortcut
    import irq_res_pkg::*;
#(
    parameter int BANK_ID = 1
) (
    input  logic [BASIC_W-1:0] basic_pend,
    output irq_result_t        res
);
    localparam int NSC  = (BANK_ID == 1) ? SC1_N : SC2_N;
    localparam int BIT0 = (BANK_ID == 1) ? SC1_BIT0 : SC2_BIT0;
    localparam int BASE = (BANK_ID == 1) ? BANK1_BASE : BANK2_BASE;

    always_comb begin
        res = RESULT_NONE;
        for (int k = NSC - 1; k >= 0; k--) begin
            if (basic_pend[BIT0 + k])
                res = make_result(NUM_W'(BASE) + NUM_W'(sc_line(BANK_ID, k)));
        end
    end
endmodule

// File: rtl/irq_res_bank_scan.sv
module irq_res_bank_scan
    import irq_res_pkg::*;
#(
    parameter int BANK_ID = 1
) (
    input  logic              summary,
    input  logic [BANK_W-1:0] bank_pend,
    output irq_result_t       res
);
    localparam int BASE = (BANK_ID == 1) ? BANK1_BASE : BANK2_BASE;
    localparam logic [BANK_W-1:0] KEEP = ~sc_mask(BANK_ID);

    logic [BANK_W-1:0] rest;

    always_comb begin
        rest = bank_pend & KEEP;
        res  = RESULT_NONE;
        if (summary && (rest != '0))
            res = make_result(NUM_W'(BASE) + NUM_W'(lowest_set(rest)));
    end
endmodule

// File: rtl/irq_desc_xlate.sv
module irq_desc_xlate
    import irq_res_pkg::*;
(
    input  logic [1:0]       desc_bank,
    input  logic [IDX_W-1:0] desc_index,
    output irq_result_t      res
);
    always_comb begin
        res = RESULT_NONE;
        case (bank_sel_e'(desc_bank))
            BANK_DIRECT:
                if (desc_index < IDX_W'(DIRECT_N))
                    res = make_result(NUM_W'(desc_index));
            BANK_ONE:
                if (desc_index < IDX_W'(BANK_W))
                    res = make_result(NUM_W'(BANK1_BASE) + NUM_W'(desc_index));
            BANK_TWO:
                if (desc_index < IDX_W'(BANK_W))
                    res = make_result(NUM_W'(BANK2_BASE) + NUM_W'(desc_index));
            default: res = RESULT_NONE;
        endcase
    end
endmodule

// File: rtl/irq_active_resolver.sv
module irq_active_resolver
    import irq_res_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BASIC_W-1:0] basic_pend,
    input  logic [BANK_W-1:0]  bank1_pend,
    input  logic [BANK_W-1:0]  bank2_pend,
    input  logic [1:0]         desc_bank,
    input  logic [IDX_W-1:0]   desc_index,
    output logic               irq_valid,
    output logic [NUM_W-1:0]   irq_num,
    output logic [NUM_W-1:0]   desc_num,
    output logic               desc_invalid
);
    // Stage order is the search priority: index 0 wins.
    irq_result_t stage [STAGES];
    irq_result_t pick;
    irq_result_t xl;

    always_comb begin
        stage[0] = RESULT_NONE;
        if (basic_pend[DIRECT_N-1:0] != '0)
            stage[0] = make_result(NUM_W'(lowest_set(BANK_W'(basic_pend[DIRECT_N-1:0]))));
    end

    irq_res_shortcut #(.BANK_ID(1)) u_sc1 (.basic_pend(basic_pend), .res(stage[1]));
    irq_res_shortcut #(.BANK_ID(2)) u_sc2 (.basic_pend(basic_pend), .res(stage[2]));

    irq_res_bank_scan #(.BANK_ID(1)) u_bk1 (
        .summary(basic_pend[SUM1_BIT]), .bank_pend(bank1_pend), .res(stage[3]));
    irq_res_bank_scan #(.BANK_ID(2)) u_bk2 (
        .summary(basic_pend[SUM2_BIT]), .bank_pend(bank2_pend), .res(stage[4]));

    always_comb begin
        pick = RESULT_NONE;
        for (int s = STAGES - 1; s >= 0; s--)
            if (stage[s].valid) pick = stage[s];
    end

    generate
        if (REG_OUT) begin : g_reg
            irq_result_t held;
            always_ff @(posedge clk) begin
                if (rst) held <= RESULT_NONE;
                else     held <= pick;
            end
            assign irq_valid = held.valid;
            assign irq_num   = held.num;
        end else begin : g_comb
            assign irq_valid = pick.valid;
            assign irq_num   = pick.num;
        end
    endgenerate

    irq_desc_xlate u_xlate (.desc_bank(desc_bank), .desc_index(desc_index), .res(xl));

    assign desc_num     = xl.num;
    assign desc_invalid = !xl.valid;
endmodule

// File: rtl/irq_res_checker.sv
module irq_res_checker
    import irq_res_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [BASIC_W-1:0] basic_pend,
    input logic               irq_valid,
    input logic [NUM_W-1:0]   irq_num,
    input logic [1:0]         desc_bank,
    input logic [NUM_W-1:0]   desc_num,
    input logic               desc_invalid
);
    // Basic word aligned with the result it produced.
    logic [BASIC_W-1:0] seen;
    logic               ready;

    generate
        if (REG_OUT) begin : g_lag
            always_ff @(posedge clk) begin
                if (rst) begin
                    seen  <= '0;
                    ready <= 1'b0;
                end else begin
                    seen  <= basic_pend;
                    ready <= 1'b1;
                end
            end
        end else begin : g_now
            assign seen  = basic_pend;
            assign ready = 1'b1;
        end
    endgenerate

    assert_idle_invalid_R1: assert property (@(posedge clk) disable iff (rst)
        (ready && seen == '0) |-> !irq_valid);

    assert_none_code_R1: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> irq_num == NUM_NONE);

    assert_num_range_R1: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> irq_num < NUM_W'(SOURCES));

    assert_direct_first_R2: assert property (@(posedge clk) disable iff (rst)
        (ready && seen[DIRECT_N-1:0] != '0) |-> (irq_valid && irq_num < NUM_W'(DIRECT_N)));

    assert_first_shortcut_R3: assert property (@(posedge clk) disable iff (rst)
        (ready && seen[DIRECT_N-1:0] == '0 && seen[SC1_BIT0]) |-> (irq_valid && irq_num == 7'd15));

    assert_bank2_shortcut_R4: assert property (@(posedge clk) disable iff (rst)
        (ready && seen[DIRECT_N-1:0] == '0 && seen[SC2_BIT0-1:SC1_BIT0] == '0 && seen[SC2_BIT0])
        |-> (irq_valid && irq_num == 7'd61));

    assert_desc_range_R8: assert property (@(posedge clk) disable iff (rst)
        !desc_invalid |-> desc_num < NUM_W'(SOURCES));

    assert_bad_bank_R9: assert property (@(posedge clk) disable iff (rst)
        (desc_bank == 2'd3) |-> (desc_invalid && desc_num == NUM_NONE));
endmodule

bind irq_active_resolver irq_res_checker #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst(rst), .basic_pend(basic_pend),
    .irq_valid(irq_valid), .irq_num(irq_num),
    .desc_bank(desc_bank), .desc_num(desc_num), .desc_invalid(desc_invalid)
);

// File: tb/irq_active_resolver_test.sv
module irq_active_resolver_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] basic_pend = '0;
    logic [31:0] bank1_pend = '0;
    logic [31:0] bank2_pend = '0;
    logic [1:0]  desc_bank = '0;
    logic [5:0]  desc_index = '0;
    logic        irq_valid;
    logic [6:0]  irq_num;
    logic [6:0]  desc_num;
    logic        desc_invalid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_active_resolver uut (
        .clk(clk), .rst(rst), .basic_pend(basic_pend),
        .bank1_pend(bank1_pend), .bank2_pend(bank2_pend),
        .desc_bank(desc_bank), .desc_index(desc_index),
        .irq_valid(irq_valid), .irq_num(irq_num),
        .desc_num(desc_num), .desc_invalid(desc_invalid)
    );

    task automatic check_res(string req, logic ev, logic [6:0] en);
        checks++;
        if (irq_valid !== ev || irq_num !== en) begin
            failures++;
            $display("FAIL %s: valid=%0b num=%0d expected valid=%0b num=%0d",
                     req, irq_valid, irq_num, ev, en);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge (one register).
    task automatic resolve(string req, logic [20:0] b, logic [31:0] p1, logic [31:0] p2,
                           logic ev, logic [6:0] en);
        @(negedge clk);
        basic_pend = b;
        bank1_pend = p1;
        bank2_pend = p2;
        @(negedge clk);
        check_res(req, ev, en);
    endtask

    task automatic xlate(string req, logic [1:0] bk, logic [5:0] idx, logic einv, logic [6:0] en);
        desc_bank  = bk;
        desc_index = idx;
        #1;
        checks++;
        if (desc_invalid !== einv || desc_num !== en) begin
            failures++;
            $display("FAIL %s: invalid=%0b num=%0d expected invalid=%0b num=%0d",
                     req, desc_invalid, desc_num, einv, en);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        basic_pend = 21'h1;
        @(negedge clk);
        check_res("R10 reset holds none", 1'b0, 7'h7F);
        basic_pend = '0;
        rst = 1'b0;
    endtask

    task automatic test_idle();
        resolve("R1 nothing pending", 21'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 7'h7F);
    endtask

    task automatic test_direct();
        resolve("R2 lowest direct", 21'h1FFCA4, 32'h1, 32'h1, 1'b1, 7'd2);
        resolve("R2 direct beats shortcut", 21'h001080, 32'h0, 32'h0, 1'b1, 7'd7);
    endtask

    task automatic test_shortcuts();
        resolve("R3 line 10 before 18", 21'h003000, 32'h0, 32'h0, 1'b1, 7'd18);
        resolve("R3 bank1 before bank2", 21'h00C000 | 21'h008000, 32'h0, 32'h0, 1'b1, 7'd27);
        resolve("R3 line 19 vs bank2 line 21", 21'h00C000, 32'h0, 32'h0, 1'b1, 7'd27);
        resolve("R4 line 23 before 30", 21'h120000, 32'h0, 32'h0, 1'b1, 7'd63);
        resolve("R4 line 30 alone", 21'h100000, 32'h0, 32'h0, 1'b1, 7'd70);
        resolve("R4 shortcut before summary", 21'h010100, 32'h1, 32'h0, 1'b1, 7'd62);
    endtask

    task automatic test_banks();
        resolve("R5 bank1 masked lowest", 21'h000100, 32'h0000_1280, 32'h0, 1'b1, 7'd20);
        resolve("R5 bank1 before bank2", 21'h000300, 32'h8000_0000, 32'h1, 1'b1, 7'd39);
        resolve("R6 bank2 masked lowest", 21'h000200, 32'h0, 32'hC020_0000 | 32'h0020_0000, 1'b1, 7'd71);
        resolve("R6 bank2 bit 0", 21'h000200, 32'h0, 32'h0000_0001, 1'b1, 7'd40);
    endtask

    task automatic test_move_on();
        resolve("R7 empty bank1 moves to bank2", 21'h000300, 32'h000C_0680, 32'h0000_0020, 1'b1, 7'd45);
        resolve("R7 empty bank1 gives none", 21'h000100, 32'h0008_0080, 32'h0, 1'b0, 7'h7F);
        resolve("R7 bank words without summary", 21'h0, 32'h0000_0001, 32'h0000_0001, 1'b0, 7'h7F);
        resolve("R7 empty bank2 gives none", 21'h000200, 32'h0, 32'h43E0_0000, 1'b0, 7'h7F);
    endtask

    task automatic test_latency();
        @(negedge clk);
        basic_pend = '0;
        @(negedge clk);
        basic_pend = 21'h000010;
        #1;
        check_res("R10 not before the edge", 1'b0, 7'h7F);
        @(negedge clk);
        check_res("R10 one clock later", 1'b1, 7'd4);
        basic_pend = 21'h000008;
        @(negedge clk);
        check_res("R10 updates every cycle", 1'b1, 7'd3);
    endtask

    task automatic test_xlate();
        xlate("R8 bank0 index 0", 2'd0, 6'd0, 1'b0, 7'd0);
        xlate("R8 bank0 index 7", 2'd0, 6'd7, 1'b0, 7'd7);
        xlate("R8 bank1 index 0", 2'd1, 6'd0, 1'b0, 7'd8);
        xlate("R8 bank1 index 31", 2'd1, 6'd31, 1'b0, 7'd39);
        xlate("R8 bank2 index 0", 2'd2, 6'd0, 1'b0, 7'd40);
        xlate("R8 bank2 index 31", 2'd2, 6'd31, 1'b0, 7'd71);
        xlate("R9 bank0 index 8", 2'd0, 6'd8, 1'b1, 7'h7F);
        xlate("R9 bank1 index 32", 2'd1, 6'd32, 1'b1, 7'h7F);
        xlate("R9 bank2 index 63", 2'd2, 6'd63, 1'b1, 7'h7F);
        xlate("R9 bank code 3", 2'd3, 6'd0, 1'b1, 7'h7F);
    endtask

    initial begin
        test_reset();
        test_idle();
        test_direct();
        test_shortcuts();
        test_banks();
        test_move_on();
        test_latency();
        test_xlate();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule